// File: doc/BRIEF.md
# Display Engine Control Register Bank

This block is the 32-bit memory-mapped control register bank that sits between a host bus and the raster timing generator of a display engine. It stores the run and master enables, the dot-clock and count-bypass mode bits, the FIFO flush bit, the underflow recovery enable, the frame size word, the buffer addresses and five raster timing words. It drives each of these to the timing generator as a plain output.

Each writable register has three write views. A write at the register's base address replaces it. A write four bytes above ORs the data into it. A write eight bytes above clears every bit that is 1 in the data. Software can therefore flip single bits without a read-modify-write.

A one-cycle end-of-frame pulse from the timing generator has three effects. It sets a sticky frame-done flag, whose enabled value forms the interrupt. It copies the queued next-buffer address into the current-buffer register. It completes a pending stop request, so the run readback that software polls falls to zero only at a frame boundary.

Top module: `dispctl_regbank`

## Requirements
- R1: After reset every register reads as zero and every control output, including `irq_o`, is 0.
- R2: The register slot is addr[7:4] and the view is addr[3:2]. A write with view 0 stores the data in slots 0x0, 0x1, 0x2, 0x3, 0x5 and 0x7 to 0xB. A read at view 0, 1, 2 or 3 of a mapped slot returns the stored value.
- R3: A write with view 1 (offset +4) ORs the write data into the stored value.
- R4: A write with view 2 (offset +8) clears every stored bit for which the write data bit is 1.
- R5: Slots 0x6 and 0xC to 0xF read as zero and ignore writes. Writes with view 3 (offset +0xC) are ignored in every slot.
- R6: Bit 9 of slot 0x1 is the frame-done flag. It is set in the cycle after `eof_i` is high. View 0 and view 1 writes do not change it. A view 2 write with data bit 9 set clears it. When that clear and `eof_i` arrive in the same cycle, the flag stays set.
- R7: `irq_o` is high exactly when the frame-done flag and bit 13 of slot 0x1 are both 1.
- R8: Bit 0 of slot 0x0 is run, and `run_o` mirrors it. Clearing run while it is 1 leaves the readback and `run_o` at 1 and records a pending stop. The first `eof_i` in a later cycle then drops run to 0. Writing run to 1 before that cancels the pending stop.
- R9: Slot 0x4 holds the current-buffer address and ignores writes. Each `eof_i` loads it with the value that slot 0x5, the next-buffer address, held before that edge.
- R10: `master_o`, `dotclk_o` and `bypass_o` mirror bits 5, 17 and 19 of slot 0x0. `fifo_clr_o` and `recover_o` mirror bits 21 and 24 of slot 0x1. `ctrl2_o`, `xfer_cnt_o` and `cur_buf_o` mirror slots 0x2, 0x3 and 0x4. `tmg_cfg_o` carries slots 0x7 to 0xB, with slot 0x7 in the least significant word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the current address |
| addr_i | input | 8 | Byte address: slot in [7:4], view in [3:2] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| eof_i | input | 1 | One-cycle end-of-frame pulse from the timing generator |
| irq_o | output | 1 | Frame-done interrupt |
| run_o | output | 1 | Run enable |
| master_o | output | 1 | Bus master enable |
| dotclk_o | output | 1 | Dot-clock interface mode |
| bypass_o | output | 1 | Transfer count bypass |
| fifo_clr_o | output | 1 | FIFO flush |
| recover_o | output | 1 | Recovery on underflow enable |
| ctrl2_o | output | 32 | Slot 0x2 contents |
| xfer_cnt_o | output | 32 | Frame size word |
| cur_buf_o | output | 32 | Current-buffer address |
| tmg_cfg_o | output | 160 | Five timing words, slot 0x7 lowest |

## Verification
Directed sequences exercise each view on registers that already hold a mixed bit pattern. These sequences distinguish OR and AND-NOT merges from a plain overwrite, and they show that view 3 and unmapped slots leave storage untouched. Dedicated cases test the set-wins collision between `eof_i` and a frame-done clear. They also test a stop request that is cancelled before the frame ends, one that lands in the same cycle as `eof_i`, and a next-buffer write that coincides with the frame boundary. A long random mix of writes on all slots and views, with sparse end-of-frame pulses, then compares every readback and output against a bench model. This mix catches wrong priorities between the run handshake, the sticky flag and the buffer copy.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int DCR_DW     = 32;
    localparam int DCR_AW     = 8;
    localparam int DCR_NSLOT  = 16;
    localparam int DCR_SLOT_W = $clog2(DCR_NSLOT);

    // slot numbers (addr[7:4])
    localparam int SLOT_CTRL  = 0;
    localparam int SLOT_CTRL1 = 1;
    localparam int SLOT_CTRL2 = 2;
    localparam int SLOT_XFER  = 3;
    localparam int SLOT_CUR   = 4;
    localparam int SLOT_NEXT  = 5;
    localparam int SLOT_TMG0  = 7;

    // readable slots and writable slots
    localparam logic [DCR_NSLOT-1:0] MAP_MASK = 16'h0FBF;
    localparam logic [DCR_NSLOT-1:0] WR_MASK  = 16'h0FAF;

    // bit positions in the control words
    localparam int B_RUN     = 0;
    localparam int B_MASTER  = 5;
    localparam int B_DOTCLK  = 17;
    localparam int B_BYPASS  = 19;
    localparam int B_DONE    = 9;
    localparam int B_DONE_EN = 13;
    localparam int B_FIFOCLR = 21;
    localparam int B_RECOVER = 24;

    typedef enum logic [1:0] {
        VIEW_BASE = 2'd0,
        VIEW_SET  = 2'd1,
        VIEW_CLR  = 2'd2,
        VIEW_RSVD = 2'd3
    } view_e;

    typedef struct packed {
        logic [DCR_NSLOT-1:0][DCR_DW-1:0] regs;
        logic                             stop_pend;
    } bank_t;

endpackage

// File: rtl/dcr_addr_dec.sv
module dcr_addr_dec
    import dcr_pkg::*;
#(
    parameter int                 AW       = DCR_AW,
    parameter int                 NSLOT    = DCR_NSLOT,
    parameter logic [NSLOT-1:0]   MAPPED   = MAP_MASK,
    localparam int                SLOT_W   = $clog2(NSLOT)
) (
    input  logic              wr_en_i,
    input  logic [AW-1:0]     addr_i,
    output logic [SLOT_W-1:0] slot_o,
    output view_e             view_o,
    output logic              mapped_o,
    output logic [NSLOT-1:0]  wr_hit_o
);

    logic unused_lsb;

    assign slot_o     = addr_i[AW-1 -: SLOT_W];
    assign view_o     = view_e'(addr_i[3:2]);
    assign mapped_o   = MAPPED[slot_o];
    assign unused_lsb = ^addr_i[1:0];

    for (genvar g = 0; g < NSLOT; g++) begin : g_hit
        assign wr_hit_o[g] = wr_en_i && mapped_o && (slot_o == SLOT_W'(g))
                             && (view_o != VIEW_RSVD);
    end

endmodule

// File: rtl/dcr_bit_merge.sv
module dcr_bit_merge
    import dcr_pkg::*;
#(
    parameter int DW = DCR_DW
) (
    input  logic [DW-1:0] old_i,
    input  logic [DW-1:0] wdata_i,
    input  view_e         view_i,
    output logic [DW-1:0] new_o
);

    always_comb begin
        unique case (view_i)
            VIEW_BASE: new_o = wdata_i;
            VIEW_SET:  new_o = old_i | wdata_i;
            VIEW_CLR:  new_o = old_i & ~wdata_i;
            default:   new_o = old_i;
        endcase
    end

endmodule

// File: rtl/dispctl_regbank.sv
module dispctl_regbank
    import dcr_pkg::*;
#(
    parameter int  DW    = DCR_DW,
    parameter int  AW    = DCR_AW,
    parameter int  N_TMG = 5,
    localparam int NSLOT  = DCR_NSLOT,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       wdata_i,
    output logic [DW-1:0]       rdata_o,
    input  logic                eof_i,
    output logic                irq_o,
    output logic                run_o,
    output logic                master_o,
    output logic                dotclk_o,
    output logic                bypass_o,
    output logic                fifo_clr_o,
    output logic                recover_o,
    output logic [DW-1:0]       ctrl2_o,
    output logic [DW-1:0]       xfer_cnt_o,
    output logic [DW-1:0]       cur_buf_o,
    output logic [N_TMG*DW-1:0] tmg_cfg_o
);

    bank_t st_d, st_q;

    logic [SLOT_W-1:0]          slot;
    view_e                      view;
    logic                       mapped;
    logic [NSLOT-1:0]           wr_hit;
    logic [NSLOT-1:0][DW-1:0]   merged;
    logic                       run_set_req;
    logic                       done_clr;

    dcr_addr_dec #(
        .AW     (AW),
        .NSLOT  (NSLOT),
        .MAPPED (MAP_MASK)
    ) i_dec (
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .slot_o   (slot),
        .view_o   (view),
        .mapped_o (mapped),
        .wr_hit_o (wr_hit)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (WR_MASK[g]) begin : g_wr
            dcr_bit_merge #(.DW(DW)) i_merge (
                .old_i   (st_q.regs[g]),
                .wdata_i (wdata_i),
                .view_i  (view),
                .new_o   (merged[g])
            );
        end else begin : g_ro
            assign merged[g] = st_q.regs[g];
        end
    end

    assign run_set_req = wr_hit[SLOT_CTRL] && merged[SLOT_CTRL][B_RUN];
    assign done_clr    = wr_hit[SLOT_CTRL1] && (view == VIEW_CLR) && wdata_i[B_DONE];

    always_comb begin
        st_d = st_q;

        for (int i = 0; i < NSLOT; i++) begin
            if (wr_hit[i] && WR_MASK[i]) begin
                st_d.regs[i] = merged[i];
            end
        end

        // sticky frame-done flag: only the clear view clears it, eof wins
        st_d.regs[SLOT_CTRL1][B_DONE] = (st_q.regs[SLOT_CTRL1][B_DONE] & ~done_clr) | eof_i;

        // run-stop handshake
        if (wr_hit[SLOT_CTRL]) begin
            if (merged[SLOT_CTRL][B_RUN]) begin
                st_d.stop_pend = 1'b0;
            end else if (st_q.regs[SLOT_CTRL][B_RUN]) begin
                st_d.regs[SLOT_CTRL][B_RUN] = 1'b1;
                st_d.stop_pend              = 1'b1;
            end
        end
        if (eof_i && st_q.stop_pend && !run_set_req) begin
            st_d.regs[SLOT_CTRL][B_RUN] = 1'b0;
            st_d.stop_pend              = 1'b0;
        end

        // frame boundary: queued buffer becomes current
        if (eof_i) begin
            st_d.regs[SLOT_CUR] = st_q.regs[SLOT_NEXT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o    = mapped ? st_q.regs[slot] : '0;
    assign irq_o      = st_q.regs[SLOT_CTRL1][B_DONE] & st_q.regs[SLOT_CTRL1][B_DONE_EN];
    assign run_o      = st_q.regs[SLOT_CTRL][B_RUN];
    assign master_o   = st_q.regs[SLOT_CTRL][B_MASTER];
    assign dotclk_o   = st_q.regs[SLOT_CTRL][B_DOTCLK];
    assign bypass_o   = st_q.regs[SLOT_CTRL][B_BYPASS];
    assign fifo_clr_o = st_q.regs[SLOT_CTRL1][B_FIFOCLR];
    assign recover_o  = st_q.regs[SLOT_CTRL1][B_RECOVER];
    assign ctrl2_o    = st_q.regs[SLOT_CTRL2];
    assign xfer_cnt_o = st_q.regs[SLOT_XFER];
    assign cur_buf_o  = st_q.regs[SLOT_CUR];

    for (genvar t = 0; t < N_TMG; t++) begin : g_tmg
        assign tmg_cfg_o[t*DW +: DW] = st_q.regs[SLOT_TMG0 + t];
    end

endmodule

// File: rtl/dcr_checker.sv
module dcr_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        eof_i,
    input logic [7:0]  addr_i,
    input logic [31:0] rdata_o,
    input logic        irq_o,
    input logic        run_o,
    input logic [31:0] cur_buf_o,
    input logic        irq_en_i,
    input logic        done_i
);

    p_unmapped_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i[7:4] == 4'd6 || addr_i[7:4] > 4'd11) |-> (rdata_o == 32'd0));

    p_eof_sets_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eof_i |=> done_i);

    p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |-> !irq_o);

    p_run_drop_at_eof_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(run_o) |-> $past(eof_i));

    p_cur_buf_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !eof_i |=> $stable(cur_buf_o));

endmodule

bind dispctl_regbank dcr_checker i_dcr_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eof_i     (eof_i),
    .addr_i    (addr_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .run_o     (run_o),
    .cur_buf_o (cur_buf_o),
    .irq_en_i  (st_q.regs[1][13]),
    .done_i    (st_q.regs[1][9])
);

// File: tb/test_dispctl_regbank.sv
module test_dispctl_regbank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = 8'd0;
    logic [31:0]  wdata = 32'd0;
    logic         eof = 1'b0;
    logic [31:0]  rdata, ctrl2, xfer, cur_buf;
    logic [159:0] tmg;
    logic         irq, run, master, dotclk, bypass, fifo_clr, recover;

    int checks = 0;
    int errors = 0;

    logic [31:0] m [16];
    logic        mpend;

    always #4 clk = ~clk;

    dispctl_regbank i_dispctl_regbank (
        .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .addr_i (addr),
        .wdata_i (wdata), .rdata_o (rdata), .eof_i (eof), .irq_o (irq),
        .run_o (run), .master_o (master), .dotclk_o (dotclk), .bypass_o (bypass),
        .fifo_clr_o (fifo_clr), .recover_o (recover), .ctrl2_o (ctrl2),
        .xfer_cnt_o (xfer), .cur_buf_o (cur_buf), .tmg_cfg_o (tmg)
    );

    function automatic logic is_mapped(input logic [3:0] s);
        return (s != 4'd6) && (s < 4'd12);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_update(input logic w, input logic [7:0] a, input logic [31:0] d,
                                input logic e);
        logic [3:0]  s = a[7:4];
        logic [1:0]  v = a[3:2];
        logic [31:0] o, n;
        logic        oldpend = mpend;
        logic [31:0] oldnext = m[5];
        logic        setreq = 1'b0;
        if (w && v != 2'd3 && is_mapped(s)) begin
            o = m[s];
            n = (v == 2'd0) ? d : (v == 2'd1) ? (o | d) : (o & ~d);
            if (s == 4'd1) n[9] = o[9] & ~((v == 2'd2) && d[9]);
            if (s == 4'd0) begin
                if (n[0]) begin mpend = 1'b0; setreq = 1'b1; end
                else if (o[0]) begin n[0] = 1'b1; mpend = 1'b1; end
            end
            if (s != 4'd4) m[s] = n;
        end
        if (e) m[1][9] = 1'b1;
        if (e && oldpend && !setreq) begin m[0][0] = 1'b0; mpend = 1'b0; end
        if (e) m[4] = oldnext;
    endtask

    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic e);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; eof = e;
        @(posedge clk);
        model_update(w, a, d, e);
        @(negedge clk);
        wr_en = 1'b0; eof = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        @(negedge clk);
        wr_en = 1'b0; eof = 1'b0; addr = a;
        #1;
        check(tag, rdata, is_mapped(a[7:4]) ? m[a[7:4]] : 32'd0);
    endtask

    task automatic outs(input string tag);
        #1;
        check({tag, " R7 irq"}, {31'd0, irq}, {31'd0, m[1][9] & m[1][13]});
        check({tag, " R8 run"}, {31'd0, run}, {31'd0, m[0][0]});
        check({tag, " R10 ctl"}, {26'd0, master, dotclk, bypass, fifo_clr, recover, 1'b0},
              {26'd0, m[0][5], m[0][17], m[0][19], m[1][21], m[1][24], 1'b0});
        check({tag, " R10 ctrl2"}, ctrl2, m[2]);
        check({tag, " R10 xfer"}, xfer, m[3]);
        check({tag, " R9 cur"}, cur_buf, m[4]);
        for (int t = 0; t < 5; t++) check({tag, " R10 tmg"}, tmg[t*32 +: 32], m[7+t]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m[i] = 32'd0;
        mpend = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 16; i++) begin
            @(negedge clk) addr = 8'(i << 4); #1;
            check("R1 reset read", rdata, 32'd0);
        end
        outs("R1 reset");

        // R2 plain writes
        cyc(1, 8'h20, 32'hA5A5_1234, 0); rd("R2 ctrl2", 8'h20);
        check("R2 literal", rdata, 32'hA5A5_1234);
        cyc(1, 8'hB0, 32'h0000_BEEF, 0); rd("R2 tmg4 via set view", 8'hB4);

        // R3 set, R4 clear
        cyc(1, 8'h30, 32'h0000_00F0, 0);
        cyc(1, 8'h34, 32'h0000_0F01, 0); rd("R3 set", 8'h30);
        check("R3 literal", rdata, 32'h0000_0FF1);
        cyc(1, 8'h38, 32'h0000_00F0, 0); rd("R4 clr", 8'h30);
        check("R4 literal", rdata, 32'h0000_0F01);

        // R5 unmapped and reserved view
        cyc(1, 8'h60, 32'hFFFF_FFFF, 0); rd("R5 slot6", 8'h60);
        cyc(1, 8'hE0, 32'hFFFF_FFFF, 0); rd("R5 slotE", 8'hE0);
        cyc(1, 8'h2C, 32'h0000_0000, 0); rd("R5 view3", 8'h20);
        check("R5 literal", rdata, 32'hA5A5_1234);

        // R6 sticky flag, R7 irq
        cyc(0, 8'h00, 0, 1); rd("R6 eof sets", 8'h10);
        check("R6 literal", rdata, 32'h0000_0200);
        cyc(1, 8'h10, 32'h0, 0); rd("R6 plain write keeps", 8'h10);
        outs("R7 disabled");
        cyc(1, 8'h14, 32'h0000_2000, 0); outs("R7 enabled");
        check("R7 literal", {31'd0, irq}, 32'd1);
        cyc(1, 8'h18, 32'h0000_0200, 1); rd("R6 set wins", 8'h10);
        cyc(1, 8'h18, 32'h0000_0200, 0); rd("R6 cleared", 8'h10);
        outs("R7 after clear");

        // R8 run stop handshake
        cyc(1, 8'h04, 32'h1, 0);
        cyc(1, 8'h08, 32'h1, 0); rd("R8 pending readback", 8'h00);
        check("R8 held literal", {31'd0, run}, 32'd1);
        repeat (3) cyc(0, 8'h00, 0, 0);
        outs("R8 idle");
        cyc(0, 8'h00, 0, 1); outs("R8 eof");
        check("R8 stopped literal", {31'd0, run}, 32'd0);
        cyc(1, 8'h04, 32'h1, 0); cyc(1, 8'h08, 32'h1, 0);
        cyc(1, 8'h04, 32'h1, 0); cyc(0, 8'h00, 0, 1); outs("R8 cancel");
        cyc(1, 8'h08, 32'h1, 1); outs("R8 clear at eof");
        cyc(0, 8'h00, 0, 1); outs("R8 next eof");

        // R9 buffers
        cyc(1, 8'h50, 32'h8000_1000, 0);
        cyc(1, 8'h40, 32'h1234_5678, 0); rd("R9 cur ignores write", 8'h40);
        cyc(1, 8'h50, 32'h8000_2000, 1); outs("R9 copy old next");
        check("R9 literal", cur_buf, 32'h8000_1000);

        // R10 control bits
        cyc(1, 8'h04, 32'h000A_0020, 0);
        cyc(1, 8'h14, 32'h0120_0000, 0); outs("R10 bits");

        // random mix
        void'($urandom(32'd2024));
        for (int k = 0; k < 600; k++) begin
            logic [7:0]  a = {4'($urandom_range(15)), 2'($urandom_range(3)), 2'b00};
            logic [31:0] d = $urandom;
            logic        e = ($urandom_range(7) == 0);
            logic        w = ($urandom_range(3) != 0);
            cyc(w, a, d, e);
            rd("R2 random read", {a[7:4], 2'($urandom_range(3)), 2'b00});
            if (k % 8 == 0) outs("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule